// File: doc/BRIEF.md
# Interrupt Event Vector Unit for a Two-Wire Bus Controller

This block gathers the one-cycle event pulses raised by a two-wire serial bus controller and latches each one in a flag: arbitration lost, no-acknowledge, access ready, receive data ready, transmit ready, stop seen, and addressed as a target. An enable mask decides which flags may interrupt. One level-sensitive request line goes high whenever an enabled flag is set.

Software reads a vector register. Each read returns a small code for one pending enabled event, and the lowest code wins. Reading the vector also retires the reported event, so a service routine can read the vector again and again until it returns zero. The two data-ready flags are the exception: a vector read does not clear them. They clear only through the data-path strobes, when the receive data is read or the transmit data is written. A status register shows every flag whatever the mask holds, together with two live bus conditions, and a flag in it is cleared by writing 1 to its bit.

The register port uses a 2-bit select with separate read and write strobes. Read data is registered: it appears one cycle after the read strobe and holds until the next read. The value returned is the one from before the read edge.

Top module: `irq_vector_unit`

## Requirements
- R1: A read with select 2 returns, in bits 2:0, the code of the lowest-indexed set flag whose mask bit is 1, or 0 if there is none. The codes are: arbitration lost 1, no-acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop seen 6, target addressed 7, so the code equals the event index plus 1. Bits 15:3 read 0.
- R2: A flag whose mask bit is 0 still latches and still shows in the status register. It never appears in the vector and never raises the request line.
- R3: An event pulse on evtIn bit k sets flag k at the next edge. When a pulse and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R4: Status (select 1) bits 6:0 are the flags, in event-index order. Writing status clears each flag whose write-data bit is 1 and leaves each flag whose bit is 0 unchanged.
- R5: A rxRead pulse clears the receive-ready flag (index 3). A txWrite pulse clears the transmit-ready flag (index 4).
- R6: A vector read clears the flag it reports, unless that flag is receive ready or transmit ready, which stay set.
- R7: irqOut is 1 exactly when some flag is set together with its mask bit, and it changes in the cycle after the edge that changes the flags or the mask.
- R8: The mask register (select 0) holds bits 6:0, is written by a write with select 0, and reads back with bits 15:7 equal to 0. Select 3 reads 0.
- R9: After reset, all flags, the mask, rdData and irqOut are 0.
- R10: Status bit 11 shows rsFull and status bit 12 shows busBusy, as sampled at the read edge. All other upper status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 7 | One-cycle event pulses, bit k = event index k |
| rsFull | input | 1 | Live receive-shift-register-full condition |
| busBusy | input | 1 | Live bus-busy condition |
| rxRead | input | 1 | Receive data register was read |
| txWrite | input | 1 | Transmit data register was written |
| regSel | input | 2 | Register select: 0 mask, 1 status, 2 vector, 3 none |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Registered read data |
| irqOut | output | 1 | Interrupt request level |

## Verification
The hardest situation to reach is a pile of coincidences in one cycle: a clear by vector read, by status write or by data strobe lands on the same flag that a new pulse is setting, while the mask hides part of the pending set. Directed sequences stage the draining of several pending events, the data-ready flags that survive a vector read, and a clear that collides with a set. A long random phase then mixes sparse event bursts with random mask writes, status clears and data strobes, so these collisions also happen with no one arranging them.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int EVT_N = 7;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_STAT = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic             maskLoad;
    logic [EVT_N-1:0] clrFlags;
    logic             rdLoad;
    regSel_e          rdSel;
  } strobe_t;
endpackage

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RSFULL_POS = 11,
  parameter int BUSY_POS   = 12,
  parameter int CODE_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EVT_N-1:0]  evtIn,
  input  logic              rsFull,
  input  logic              busBusy,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           strb,
  input  logic [CODE_W-1:0] vecCode,
  output logic [EVT_N-1:0]  flagQ,
  output logic [EVT_N-1:0]  pendQ,
  output logic [DATA_W-1:0] rdData
);
  logic [EVT_N-1:0]  maskQ;
  logic [DATA_W-1:0] rdMux;

  // set has priority over any clear arriving in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      maskQ <= '0;
    end else begin
      flagQ <= (flagQ & ~strb.clrFlags) | evtIn;
      if (strb.maskLoad) maskQ <= wrData[EVT_N-1:0];
    end
  end

  assign pendQ = flagQ & maskQ;

  always_comb begin
    rdMux = '0;
    unique case (strb.rdSel)
      SEL_MASK: rdMux[EVT_N-1:0] = maskQ;
      SEL_STAT: begin
        rdMux[EVT_N-1:0]  = flagQ;
        rdMux[RSFULL_POS] = rsFull;
        rdMux[BUSY_POS]   = busBusy;
      end
      SEL_VEC:  rdMux[CODE_W-1:0] = vecCode;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strb.rdLoad) rdData <= rdMux;
  end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int RX_IDX = 3,
  parameter int TX_IDX = 4
) (
  input  logic [1:0]        regSel,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [EVT_N-1:0]  wrBits,
  input  logic              rxRead,
  input  logic              txWrite,
  input  logic [EVT_N-1:0]  pendQ,
  output strobe_t           strb,
  output logic [CODE_W-1:0] vecCode
);
  logic [EVT_N-1:0] hitOne;
  logic [EVT_N-1:0] vecClr;
  logic [EVT_N-1:0] dataClr;
  logic [EVT_N-1:0] keepMask;
  logic             vecRead;
  logic             statWrite;

  // lowest index wins: scan from the top so the last match is the lowest
  always_comb begin
    vecCode = '0;
    hitOne  = '0;
    for (int i = EVT_N - 1; i >= 0; i--) begin
      if (pendQ[i]) begin
        vecCode   = CODE_W'(i + 1);
        hitOne    = '0;
        hitOne[i] = 1'b1;
      end
    end
  end

  always_comb begin
    keepMask         = '1;
    keepMask[RX_IDX] = 1'b0;
    keepMask[TX_IDX] = 1'b0;
    dataClr          = '0;
    dataClr[RX_IDX]  = rxRead;
    dataClr[TX_IDX]  = txWrite;
  end

  assign vecRead   = regRd && (regSel == SEL_VEC);
  assign statWrite = regWr && (regSel == SEL_STAT);
  assign vecClr    = vecRead ? (hitOne & keepMask) : '0;

  always_comb begin
    strb.maskLoad = regWr && (regSel == SEL_MASK);
    strb.clrFlags = (statWrite ? wrBits : '0) | vecClr | dataClr;
    strb.rdLoad   = regRd;
    strb.rdSel    = regSel_e'(regSel);
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RSFULL_POS = 11,
  parameter int BUSY_POS   = 12,
  parameter int RX_IDX     = 3,
  parameter int TX_IDX     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [6:0]        evtIn,
  input  logic              rsFull,
  input  logic              busBusy,
  input  logic              rxRead,
  input  logic              txWrite,
  input  logic [1:0]        regSel,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  localparam int CODE_W = $clog2(EVT_N + 1);

  strobe_t           strb;
  logic [CODE_W-1:0] vecCode;
  logic [EVT_N-1:0]  flagQ;
  logic [EVT_N-1:0]  pendQ;

  irqv_ctrl #(
    .CODE_W(CODE_W), .RX_IDX(RX_IDX), .TX_IDX(TX_IDX)
  ) uCtrl (
    .regSel(regSel), .regRd(regRd), .regWr(regWr),
    .wrBits(wrData[EVT_N-1:0]), .rxRead(rxRead), .txWrite(txWrite),
    .pendQ(pendQ), .strb(strb), .vecCode(vecCode)
  );

  irqv_datapath #(
    .DATA_W(DATA_W), .RSFULL_POS(RSFULL_POS), .BUSY_POS(BUSY_POS), .CODE_W(CODE_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .rsFull(rsFull), .busBusy(busBusy),
    .wrData(wrData), .strb(strb), .vecCode(vecCode),
    .flagQ(flagQ), .pendQ(pendQ), .rdData(rdData)
  );

  assign irqOut = |pendQ;
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter int DATA_W = 16,
  parameter int RX_IDX = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [6:0]        evtIn,
  input logic              rxRead,
  input logic [1:0]        regSel,
  input logic              regRd,
  input logic              regWr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              irqOut,
  input logic [6:0]        flagQ
);
  // R7
  vec_irq_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regSel == 2'd2) |=> ((rdData == '0) == !$past(irqOut)));

  // R1
  vec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regSel == 2'd2) |=> (rdData[DATA_W-1:3] == '0 && rdData[2:0] <= 3'd7));

  // R3
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtIn) |=> ((flagQ & $past(evtIn)) == $past(evtIn)));

  // R5
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && !evtIn[RX_IDX]) |=> !flagQ[RX_IDX]);

  // R6
  rx_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regSel == 2'd2 && flagQ[RX_IDX] && !rxRead && !regWr) |=> flagQ[RX_IDX]);

  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == 2'd1 && wrData[0] && !evtIn[0]) |=> !flagQ[0]);
endmodule

bind irq_vector_unit irqv_chk #(.DATA_W(DATA_W), .RX_IDX(RX_IDX)) uChk (
  .clk(clk), .rstN(rstN), .evtIn(evtIn), .rxRead(rxRead), .regSel(regSel),
  .regRd(regRd), .regWr(regWr), .wrData(wrData), .rdData(rdData),
  .irqOut(irqOut), .flagQ(flagQ)
);

// File: tb/tb_irq_vector_unit.sv
`timescale 1ns/1ps
module tb_irq_vector_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  evtIn = '0;
  logic        rsFull = 1'b0, busBusy = 1'b0, rxRead = 1'b0, txWrite = 1'b0;
  logic [1:0]  regSel = '0;
  logic        regRd = 1'b0, regWr = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irqOut;

  int nRun = 0;
  int nFail = 0;
  logic [6:0] mFlags = '0;
  logic [6:0] mMask = '0;

  always #2 clk = ~clk;

  irq_vector_unit dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .rsFull(rsFull), .busBusy(busBusy),
    .rxRead(rxRead), .txWrite(txWrite), .regSel(regSel), .regRd(regRd),
    .regWr(regWr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [2:0] expCode(input logic [6:0] p);
    expCode = 3'd0;
    for (int i = 6; i >= 0; i--) if (p[i]) expCode = 3'(i + 1);
  endfunction

  function automatic logic [6:0] expVecClr(input logic [6:0] p);
    logic [2:0] c;
    expVecClr = '0;
    c = expCode(p);
    if (c != 0 && c != 3'd4 && c != 3'd5) expVecClr[c-1] = 1'b1;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [6:0] e, input logic rd, input logic wr,
                     input logic [1:0] sel, input logic [15:0] d,
                     input logic rx, input logic tx, input logic rsf,
                     input logic bb, input string tag);
    logic [15:0] expRd;
    logic [6:0]  clr;
    @(negedge clk);
    evtIn = e; regRd = rd; regWr = wr; regSel = sel; wrData = d;
    rxRead = rx; txWrite = tx; rsFull = rsf; busBusy = bb;
    expRd = '0;
    case (sel)
      2'd0: expRd[6:0] = mMask;
      2'd1: begin expRd[6:0] = mFlags; expRd[11] = rsf; expRd[12] = bb; end
      2'd2: expRd[2:0] = expCode(mFlags & mMask);
      default: expRd = '0;
    endcase
    clr = '0;
    if (wr && sel == 2'd1) clr |= d[6:0];
    if (rd && sel == 2'd2) clr |= expVecClr(mFlags & mMask);
    clr[3] = clr[3] | rx;
    clr[4] = clr[4] | tx;
    mFlags = (mFlags & ~clr) | e;
    if (wr && sel == 2'd0) mMask = d[6:0];
    @(posedge clk);
    #1;
    evtIn = '0; regRd = 1'b0; regWr = 1'b0; rxRead = 1'b0; txWrite = 1'b0;
    if (rd) check(rdData, expRd, tag);
    check({15'd0, irqOut}, {15'd0, |(mFlags & mMask)}, "R7 irq level");
  endtask

  task automatic rdReg(input logic [1:0] sel, input string tag);
    cyc('0, 1'b1, 1'b0, sel, '0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [15:0] d, input string tag);
    cyc('0, 1'b0, 1'b1, sel, d, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic pulse(input logic [6:0] e, input string tag);
    cyc(e, 1'b0, 1'b0, 2'd3, '0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check(rdData, 16'h0, "R9 rdData after reset");
    check({15'd0, irqOut}, 16'h0, "R9 irq after reset");
    @(negedge clk);
    rstN = 1'b1;
    rdReg(2'd0, "R8 mask reset");
    rdReg(2'd1, "R9 status reset");
    rdReg(2'd3, "R8 select 3 reads zero");
    wrReg(2'd0, 16'hFFFF, "R8 mask write");
    rdReg(2'd0, "R8 mask readback");

    // R1 each code, R6 clear-on-read, R5 data strobes
    for (int k = 0; k < 7; k++) begin
      pulse(7'(1 << k), "R3 single event");
      rdReg(2'd2, "R1 single code");
      rdReg(2'd2, "R6 second vector read");
      if (k == 3) cyc('0, 1'b0, 1'b0, 2'd3, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 rx clear");
      if (k == 4) cyc('0, 1'b0, 1'b0, 2'd3, '0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 tx clear");
      rdReg(2'd2, "R5 vector empty");
    end

    // R1 priority drain
    pulse(7'b1000110, "R3 multi event");
    rdReg(2'd2, "R1 priority first");
    rdReg(2'd2, "R1 priority second");
    rdReg(2'd2, "R1 priority third");
    rdReg(2'd2, "R1 priority empty");

    // R2 masked flags stay in status
    wrReg(2'd0, 16'h0001, "R2 narrow mask");
    pulse(7'b0100000, "R2 masked event");
    rdReg(2'd2, "R2 masked not in vector");
    cyc('0, 1'b1, 1'b0, 2'd1, '0, 1'b0, 1'b0, 1'b1, 1'b1, "R10 status live bits");
    wrReg(2'd1, 16'h0000, "R4 write zero no effect");
    rdReg(2'd1, "R4 status unchanged");
    wrReg(2'd1, 16'h0020, "R4 write one clears");
    rdReg(2'd1, "R4 status cleared");

    // R3 set beats same-cycle clear
    cyc(7'b0000001, 1'b0, 1'b1, 2'd1, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, "R3 collide");
    rdReg(2'd1, "R3 set wins");
    wrReg(2'd1, 16'h007F, "R4 clear all");

    // random phase
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] e;
      logic [1:0] sel;
      logic rd, wr;
      e   = ($urandom % 4 == 0) ? 7'($urandom) : 7'd0;
      sel = 2'($urandom);
      rd  = ($urandom % 2) == 0;
      wr  = ($urandom % 5) == 0;
      cyc(e, rd, wr, sel, 16'($urandom), ($urandom % 6) == 0, ($urandom % 6) == 0,
          1'($urandom), 1'($urandom), "R1 random mix");
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule